// File: doc/BRIEF.md
# Latched Processor Address Output Stage

This block sits between a processor core and an external address bus. The core presents the address it wants for the next bus cycle. The block models the two-phase bus cycle with a phase signal that toggles on every clock. It captures the core address at the end of phase 1, so a new address appears during phase 2 of the cycle before its own and holds through phase 1 of the cycle it belongs to.

The captured address reaches the pins through a static transparent hold stage. While the latch enable input is high, the pins follow the captured address. While it is low, the pins keep the value they last showed, for as many cycles as the enable stays low. Holding the enable low through phase 2 keeps the address steady for a slow ROM.

A bus enable input switches every pin driver on or off, and each bit has its own output-enable signal. A width input selects the full 32-bit address space or a reduced 26-bit space. In the reduced space the upper six lines are driven to zero. A one-cycle error flag reports a width change made while the core is asking for an address that does not fit in 26 bits.

Top module: `addr_out_stage`

## Requirements
- R1: While reset is asserted, and until the first clock after it is released, phase2 is 0, range_err is 0 and pin_addr is 0.
- R2: Once out of reset, phase2 inverts on every rising clock edge. It starts at 0 (phase 1), so the first edge after reset sets it to 1.
- R3: On a rising edge where phase2 is 0, the block captures core_addr. On a rising edge where phase2 is 1, the captured value does not change.
- R4: While latch_en is 1, pin_addr shows the captured address (masked per R7) in the same cycle.
- R5: While latch_en is 0, pin_addr keeps the address it showed when latch_en fell, however many cycles pass and even though new captures happen. When latch_en returns to 1, pin_addr shows the current captured address.
- R6: bus_en controls every pin_oe bit in the same cycle: all 32 bits are 1 when bus_en is 1 and all are 0 when it is 0. bus_en has no effect on pin_addr.
- R7: When wide_mode is 1, all 32 bits of pin_addr carry the address. When it is 0, pin_addr[31:26] is 0 and pin_addr[25:0] carry the address. The effect appears in the same cycle.
- R8: range_err is 1 for the cycle after a rising edge at which both hold: wide_mode differs from its value at the previous edge, and core_addr[31:26] is nonzero (address above 0x3FFFFFF). The stored previous value of wide_mode is 1 after reset.
- R9: range_err stays 0 after an edge at which wide_mode is unchanged, or at which core_addr is at most 0x3FFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; two edges form one bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| core_addr | input | 32 | Next-cycle address from the core |
| latch_en | input | 1 | 1: pins follow the captured address; 0: pins hold |
| bus_en | input | 1 | 1: drivers on; 0: all drivers high impedance |
| wide_mode | input | 1 | 1: 32-bit address space; 0: 26-bit address space |
| phase2 | output | 1 | 1 during phase 2 of the bus cycle |
| pin_addr | output | 32 | Address value presented to the pads |
| pin_oe | output | 32 | Per-bit driver enable; 0 means high impedance |
| range_err | output | 1 | One-cycle flag for a width change on an out-of-range address |

## Verification
pin_oe and the narrow-mode masking follow their inputs in the same cycle. Address capture, the hold stage, phase2 and range_err change one rising edge after the inputs that cause them. The driver applies each input set 2 ns after a falling edge and pushes the expected result, worked out from the requirements, into a queue. The monitor pops and compares that entry 1 ns after the next falling edge, so exactly one rising edge lies between stimulus and sample, and both the same-cycle and the one-edge results are due at that moment.

// File: rtl/addr_out_pkg.sv
package addr_out_pkg;
  parameter int ADDR_W   = 32;
  parameter int NARROW_W = 26;
endpackage

// File: rtl/addr_rst_sync.sv
module addr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/addr_phase_gen.sv
module addr_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic phase2
);
  logic ph_q, ph_d;

  always_comb ph_d = ~ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign phase2 = ph_q;

  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ph_q != $past(ph_q)));
endmodule

// File: rtl/addr_capture.sv
module addr_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase2,
  input  logic [ADDR_W-1:0] core_addr,
  output logic [ADDR_W-1:0] stage_q,
  output logic [ADDR_W-1:0] stage_d
);
  logic load_en;

  always_comb begin
    load_en = ~phase2;
    stage_d = load_en ? core_addr : stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  // R3
  capture_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase2 |=> $stable(stage_q));
endmodule

// File: rtl/addr_hold_latch.sv
module addr_hold_latch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_en,
  input  logic [ADDR_W-1:0] stage_q,
  input  logic [ADDR_W-1:0] stage_d,
  output logic [ADDR_W-1:0] latch_out
);
  logic [ADDR_W-1:0] held_q, held_d;

  always_comb begin
    held_d    = latch_en ? stage_d : held_q;
    latch_out = latch_en ? stage_q : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  // R5
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> $stable(held_q));
endmodule

// File: rtl/addr_width_sel.sv
module addr_width_sel #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 26
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wide_mode,
  input  logic [ADDR_W-1:0]          addr_in,
  input  logic [ADDR_W-NARROW_W-1:0] core_hi,
  output logic [ADDR_W-1:0]          addr_out,
  output logic                       range_err
);
  localparam int HIGH_W = ADDR_W - NARROW_W;
  localparam logic [ADDR_W-1:0] NARROW_MASK = {{HIGH_W{1'b0}}, {NARROW_W{1'b1}}};

  logic wide_q, wide_d;
  logic err_q, err_d;
  logic mode_changed, high_req;

  always_comb begin
    addr_out     = wide_mode ? addr_in : (addr_in & NARROW_MASK);
    mode_changed = (wide_mode != wide_q);
    high_req     = (core_hi != '0);
    err_d        = mode_changed & high_req;
    wide_d       = wide_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      wide_q <= wide_d;
      err_q  <= err_d;
    end
  end

  assign range_err = err_q;

  // R8
  err_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(core_hi) != '0));
endmodule

// File: rtl/addr_pin_driver.sv
module addr_pin_driver (
  input  logic bit_val,
  input  logic drive_en,
  output logic pin_val,
  output logic pin_en
);
  assign pin_val = bit_val;
  assign pin_en  = drive_en;
endmodule

// File: rtl/addr_out_stage.sv
module addr_out_stage #(
  parameter int ADDR_W   = addr_out_pkg::ADDR_W,
  parameter int NARROW_W = addr_out_pkg::NARROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              latch_en,
  input  logic              bus_en,
  input  logic              wide_mode,
  output logic              phase2,
  output logic [ADDR_W-1:0] pin_addr,
  output logic [ADDR_W-1:0] pin_oe,
  output logic              range_err
);
  logic              rst_s_n;
  logic [ADDR_W-1:0] stage_q, stage_d, latch_out, masked;

  addr_rst_sync u_rst_sync (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_s_n)
  );

  addr_phase_gen u_phase (
    .clk(clk), .rst_n(rst_s_n), .phase2(phase2)
  );

  addr_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk(clk), .rst_n(rst_s_n), .phase2(phase2), .core_addr(core_addr),
    .stage_q(stage_q), .stage_d(stage_d)
  );

  addr_hold_latch #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst_n(rst_s_n), .latch_en(latch_en),
    .stage_q(stage_q), .stage_d(stage_d), .latch_out(latch_out)
  );

  addr_width_sel #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_width (
    .clk(clk), .rst_n(rst_s_n), .wide_mode(wide_mode), .addr_in(latch_out),
    .core_hi(core_addr[ADDR_W-1:NARROW_W]), .addr_out(masked),
    .range_err(range_err)
  );

  for (genvar b = 0; b < ADDR_W; b++) begin : g_drv
    addr_pin_driver u_drv (
      .bit_val(masked[b]), .drive_en(bus_en),
      .pin_val(pin_addr[b]), .pin_en(pin_oe[b])
    );
  end

  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !bus_en |-> (pin_oe == '0));

  // R6
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    bus_en |-> (pin_oe == '1));

  // R7
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wide_mode |-> (pin_addr[ADDR_W-1:NARROW_W] == '0));
endmodule

// File: tb/addr_out_stage_bench.sv
`timescale 1ns/1ps
module addr_out_stage_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] core_addr;
  logic        latch_en, bus_en, wide_mode;
  logic        phase2;
  logic [31:0] pin_addr, pin_oe;
  logic        range_err;

  always #2.5 clk = ~clk;

  addr_out_stage u_addr_out_stage (
    .clk(clk), .rst_n(rst_n), .core_addr(core_addr), .latch_en(latch_en),
    .bus_en(bus_en), .wide_mode(wide_mode), .phase2(phase2),
    .pin_addr(pin_addr), .pin_oe(pin_oe), .range_err(range_err)
  );

  int checks = 0;
  int errors = 0;

  logic        m_ph, m_wprev, m_err;
  logic [31:0] m_stage, m_held;

  logic [31:0] q_addr[$];
  logic [31:0] q_oe[$];
  logic        q_err[$];
  logic        q_ph[$];
  string       q_atag[$];
  string       q_etag[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] a, input logic le, input logic be,
                      input logic wm, input string atag, input string etag);
    logic [31:0] ev;
    @(negedge clk);
    #2;
    core_addr = a; latch_en = le; bus_en = be; wide_mode = wm;
    if (!m_ph) m_stage = a;
    if (le) m_held = m_stage;
    m_err  = (wm != m_wprev) && (a[31:26] != 6'd0);
    m_wprev = wm;
    m_ph   = ~m_ph;
    ev = le ? m_stage : m_held;
    if (!wm) ev[31:26] = 6'd0;
    q_addr.push_back(ev);
    q_oe.push_back(be ? 32'hFFFF_FFFF : 32'h0);
    q_err.push_back(m_err);
    q_ph.push_back(m_ph);
    q_atag.push_back(atag);
    q_etag.push_back(etag);
  endtask

  always @(negedge clk) begin
    #1;
    if (q_addr.size() > 0) begin
      check({q_atag.pop_front(), " pin_addr"}, pin_addr, q_addr.pop_front());
      check("R6 pin_oe", pin_oe, q_oe.pop_front());
      check({q_etag.pop_front(), " range_err"}, {31'd0, range_err}, {31'd0, q_err.pop_front()});
      check("R2 phase2", {31'd0, phase2}, {31'd0, q_ph.pop_front()});
    end
  end

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_ph = 1'b0; m_wprev = 1'b1; m_err = 1'b0; m_stage = '0; m_held = '0;
    rst_n = 1'b0;
    core_addr = 32'hDEAD_BEEF; latch_en = 1'b1; bus_en = 1'b1; wide_mode = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset pin_addr", pin_addr, 32'h0);
    check("R1 reset phase2", {31'd0, phase2}, 32'h0);
    check("R1 reset range_err", {31'd0, range_err}, 32'h0);
    core_addr = 32'h0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    step(32'h1234_5678, 1, 1, 1, "R3", "R9");
    step(32'hA5A5_0F0F, 1, 1, 1, "R3", "R9");
    step(32'hA5A5_0F0F, 1, 1, 1, "R4", "R9");
    step(32'h0BAD_F00D, 0, 1, 1, "R5", "R9");
    step(32'h0BAD_F00D, 0, 1, 1, "R5", "R9");
    step(32'h1111_2222, 0, 1, 1, "R5", "R9");
    step(32'h3333_4444, 0, 1, 1, "R5", "R9");
    step(32'h5555_6666, 0, 1, 1, "R5", "R9");
    step(32'h5555_6666, 1, 1, 1, "R5", "R9");
    step(32'h7777_8888, 1, 0, 1, "R6", "R9");
    step(32'h7777_8888, 1, 0, 1, "R6", "R9");
    step(32'hFC00_1234, 1, 1, 0, "R7", "R8");
    step(32'hFC00_1234, 1, 1, 0, "R7", "R9");
    step(32'hFC00_1234, 1, 1, 0, "R7", "R9");
    step(32'h0000_0042, 1, 1, 1, "R4", "R9");
    step(32'h0000_0042, 1, 1, 1, "R4", "R9");
    step(32'h0400_0000, 1, 1, 0, "R7", "R8");
    step(32'h03FF_FFFF, 1, 1, 1, "R4", "R9");
    step(32'h03FF_FFFF, 1, 1, 0, "R7", "R9");
    step(32'hFFFF_FFFF, 0, 1, 1, "R5", "R8");
    step(32'hFFFF_FFFF, 0, 0, 1, "R6", "R9");
    step(32'h8000_0001, 1, 1, 1, "R4", "R9");

    repeat (3) @(negedge clk);
    #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule